// File: doc/BRIEF.md
# Integrity Check Compare Controller

This block is the control and checking unit that sits in front of a 3G confidentiality/integrity engine. A host writes a mode word, a key length in bytes and a reference integrity value through a small register write port. On a start request the block checks the mode and the key length. If both are legal, it launches the cipher datapath with a one-cycle go strobe. The strobe carries the function select, the new-message initialization flag and the final-block flag. The cipher datapaths themselves live outside the block and answer with a done strobe and a 32-bit computed integrity value.

Comparison is optional. It happens only when three conditions hold together: the integrity function is selected, the compare bit is set, and the final block of the message is being processed. A mismatch is not reported as status data. It raises a sticky error flag that drives the interrupt line. Illegal function codes and key lengths that do not fit the selected function also raise sticky flags and refuse the start. The host can mask each flag away from the interrupt line and clear it by writing a 1 to its bit.

Top module: `icv_check_ctrl`

## Requirements
- R1: After reset, error flags, interrupt, busy, go strobe and done strobe are all 0, and the key length register holds 0.
- R2: Function field mode[1:0]: 00 selects the confidentiality function and 10 selects the integrity function. A legal start while idle gives exactly one go pulse, with eng_f9_o = 1 for the integrity function. busy_o is high from the go pulse until the cycle after eng_done_i, when op_done_o pulses and busy_o falls.
- R3: A start with function code 01 or 11 sets error flag bit 1 (illegal mode) and produces no go pulse.
- R4: Both functions need a key length of exactly 16 bytes. Otherwise, with a legal function code, a start sets error flag bit 2 (illegal key size) and produces no go pulse.
- R5: Key length register (address 1, data[4:0]) is cleared by reset and by any write to the re-initialize address 5.
- R6: Mode bit 4 (init) goes out as eng_init_o with the go pulse. Mode bit 3 (process-end) goes out as eng_final_o only for the integrity function and reads 0 for the confidentiality function.
- R7: With the integrity function, compare bit (mode bit 2) and process-end bit set, a done strobe whose computed value differs from the reference register (address 2) sets error flag bit 0. An equal value sets nothing.
- R8: No comparison is made, and no flag is set even on unequal values, when the compare bit is 0, the process-end bit is 0, or the confidentiality function is selected.
- R9: Error flags are sticky. A write to address 4 clears the flags whose data bits are 1. A flag being set in the same cycle as its clear stays set.
- R10: irq_o is the OR of the error flags whose mask bit (address 3, same bit positions) is 0. Masking does not alter the flags.
- R11: A start request while busy is ignored and produces no further go pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0 mode, 1 key length, 2 reference value, 3 mask, 4 flag clear, 5 re-initialize) |
| reg_wdata_i | input | 32 | Register write data |
| start_i | input | 1 | Start request for one descriptor |
| eng_go_o | output | 1 | One-cycle launch strobe to the cipher datapath |
| eng_f9_o | output | 1 | 1 = integrity function, 0 = confidentiality function |
| eng_init_o | output | 1 | Initialize for a new message |
| eng_final_o | output | 1 | Process the final block of the message |
| eng_done_i | input | 1 | Cipher datapath finished |
| eng_icv_i | input | 32 | Computed integrity value, valid with eng_done_i |
| busy_o | output | 1 | Operation in flight |
| op_done_o | output | 1 | One-cycle pulse at the end of an operation |
| err_flags_o | output | 3 | Sticky flags: bit 0 value mismatch, bit 1 illegal mode, bit 2 illegal key size |
| irq_o | output | 1 | Error interrupt |

## Verification
The two functions that can fall in the same cycle are the setting of the mismatch flag by a done strobe and the host's write-one-to-clear of that same flag. The bench provokes the collision by first leaving flag bit 0 set from an earlier mismatch. It then runs another compared integrity operation with unequal values and drives the clear write in the very cycle that eng_done_i is high. It judges the result by reading err_flags_o one cycle later: bit 0 must still be 1, and a later clear on its own must bring it to 0. Launches are tracked by a scoreboard of expected go items, so a refused or ignored start that still launches shows up as an unexpected pulse.

// File: rtl/icc_pkg.sv
// Package: shared types and constants for the integrity check compare controller.
// Assumes: the mode word layout below is what the host writes at address 0.
package icc_pkg;

    // Function select codes; bit 0 set marks a reserved code.
    typedef enum logic [1:0] {
        FN_CONF = 2'b00,
        FN_RSV1 = 2'b01,
        FN_INTG = 2'b10,
        FN_RSV3 = 2'b11
    } fn_e;

    // Mode word: bit4 init, bit3 process-end, bit2 compare, bits1:0 function.
    typedef struct packed {
        logic init;
        logic pe;
        logic cmp;
        fn_e  fn;
    } mode_t;

    localparam int MODE_W   = 5;

    // Error flag bit positions.
    localparam int ERR_ICV  = 0;
    localparam int ERR_MODE = 1;
    localparam int ERR_KEY  = 2;
    localparam int NUM_ERR  = 3;

    // Register addresses.
    localparam int A_MODE   = 0;
    localparam int A_KEY    = 1;
    localparam int A_REF    = 2;
    localparam int A_MASK   = 3;
    localparam int A_CLR    = 4;
    localparam int A_REINIT = 5;

endpackage

// File: rtl/icc_regs.sv
// Module: host-written register file (mode, key length, reference value, mask)
// plus the decoded write-one-to-clear vector for the error flags.
// Assumes: DATA_W >= ICV_W, DATA_W >= MODE_W, KEY_W and NUM_ERR.
module icc_regs
    import icc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int ICV_W  = 32,
    parameter int KEY_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output mode_t             mode_o,
    output logic [KEY_W-1:0]  key_bytes_o,
    output logic [ICV_W-1:0]  ref_icv_o,
    output logic [NUM_ERR-1:0] mask_o,
    output logic [NUM_ERR-1:0] clr_o
);

    logic hit_mode, hit_key, hit_ref, hit_mask, hit_clr, hit_reinit;

    // Address decode of the write strobe.
    always_comb begin
        hit_mode   = we_i && (addr_i == ADDR_W'(A_MODE));
        hit_key    = we_i && (addr_i == ADDR_W'(A_KEY));
        hit_ref    = we_i && (addr_i == ADDR_W'(A_REF));
        hit_mask   = we_i && (addr_i == ADDR_W'(A_MASK));
        hit_clr    = we_i && (addr_i == ADDR_W'(A_CLR));
        hit_reinit = we_i && (addr_i == ADDR_W'(A_REINIT));
    end

    // Clear vector handed to the flag bank for one cycle.
    always_comb begin
        clr_o = hit_clr ? wdata_i[NUM_ERR-1:0] : '0;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_o <= '0;
        else if (hit_mode) mode_o <= mode_t'(wdata_i[MODE_W-1:0]);
    end

    // Key length register; re-initialize clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || hit_reinit) key_bytes_o <= '0;
        else if (hit_key)         key_bytes_o <= wdata_i[KEY_W-1:0];
    end

    // Reference integrity value register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ref_icv_o <= '0;
        else if (hit_ref) ref_icv_o <= wdata_i[ICV_W-1:0];
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_o <= '0;
        else if (hit_mask) mask_o <= wdata_i[NUM_ERR-1:0];
    end

endmodule

// File: rtl/icc_validate.sv
// Module: combinational legality check of the function code and key length.
// Assumes: every legal function uses the same required key length REQ_KEY.
module icc_validate
    import icc_pkg::*;
#(
    parameter int KEY_W   = 5,
    parameter int REQ_KEY = 16
) (
    input  mode_t            mode_i,
    input  logic [KEY_W-1:0] key_bytes_i,
    output logic             mode_bad_o,
    output logic             key_bad_o
);

    // A reserved code has bit 0 set; key length is judged only for legal codes.
    always_comb begin
        mode_bad_o = (mode_i.fn == FN_RSV1) || (mode_i.fn == FN_RSV3);
        key_bad_o  = !mode_bad_o && (key_bytes_i != KEY_W'(REQ_KEY));
    end

endmodule

// File: rtl/icc_seq.sv
// Module: launch sequencer. Accepts a start while idle, snapshots the mode,
// pulses the datapath, waits for done and performs the optional compare.
// Assumes: eng_done_i is only meaningful while busy; the reference register
// is read live at the done cycle.
module icc_seq
    import icc_pkg::*;
#(
    parameter int ICV_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  mode_t              mode_i,
    input  logic               mode_bad_i,
    input  logic               key_bad_i,
    input  logic               eng_done_i,
    input  logic [ICV_W-1:0]   eng_icv_i,
    input  logic [ICV_W-1:0]   ref_icv_i,
    output logic               busy_o,
    output logic               eng_go_o,
    output logic               eng_f9_o,
    output logic               eng_init_o,
    output logic               eng_final_o,
    output logic               op_done_o,
    output logic [NUM_ERR-1:0] set_o
);

    typedef enum logic {S_IDLE, S_RUN} state_e;

    state_e state_q;
    mode_t  snap_q;
    logic   accept, finish, do_cmp;

    // Start acceptance and end-of-operation detection.
    always_comb begin
        accept = start_i && (state_q == S_IDLE) && !mode_bad_i && !key_bad_i;
        finish = (state_q == S_RUN) && eng_done_i;
        do_cmp = (snap_q.fn == FN_INTG) && snap_q.cmp && snap_q.pe;
    end

    // Error set requests toward the flag bank.
    always_comb begin
        set_o           = '0;
        set_o[ERR_MODE] = start_i && (state_q == S_IDLE) && mode_bad_i;
        set_o[ERR_KEY]  = start_i && (state_q == S_IDLE) && key_bad_i;
        set_o[ERR_ICV]  = finish && do_cmp && (eng_icv_i != ref_icv_i);
    end

    // Two-state control: idle until accepted, running until done.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= S_IDLE;
        else if (accept) state_q <= S_RUN;
        else if (finish) state_q <= S_IDLE;
    end

    // Mode snapshot taken at launch, used for the compare decision.
    always_ff @(posedge clk) begin
        if (!rst_n)      snap_q <= '0;
        else if (accept) snap_q <= mode_i;
    end

    // Launch strobe and its qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_go_o    <= 1'b0;
            eng_f9_o    <= 1'b0;
            eng_init_o  <= 1'b0;
            eng_final_o <= 1'b0;
        end else begin
            eng_go_o <= accept;
            if (accept) begin
                eng_f9_o    <= (mode_i.fn == FN_INTG);
                eng_init_o  <= mode_i.init;
                eng_final_o <= mode_i.pe && (mode_i.fn == FN_INTG);
            end
        end
    end

    // End-of-operation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) op_done_o <= 1'b0;
        else        op_done_o <= finish;
    end

    // Busy indication.
    always_comb begin
        busy_o = (state_q == S_RUN);
    end

endmodule

// File: rtl/icc_errs.sv
// Module: sticky error flag bank with write-one-to-clear and masked interrupt.
// Assumes: a set and a clear of the same bit in one cycle resolve to set.
module icc_errs #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);

    // One sticky flop per error source.
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flags_o[g] <= 1'b0;
            else        flags_o[g] <= set_i[g] || (flags_o[g] && !clr_i[g]);
        end
    end

    // Interrupt from unmasked flags.
    always_comb begin
        irq_o = |(flags_o & ~mask_i);
    end

endmodule

// File: rtl/icv_check_ctrl.sv
// Module: top of the integrity check compare controller. Ties the register
// file, legality check, launch sequencer and error flag bank together.
// Assumes: the cipher datapath answers every go pulse with one done strobe.
module icv_check_ctrl
    import icc_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32,
    parameter int ICV_W   = 32,
    parameter int KEY_W   = 5,
    parameter int REQ_KEY = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    input  logic               start_i,
    output logic               eng_go_o,
    output logic               eng_f9_o,
    output logic               eng_init_o,
    output logic               eng_final_o,
    input  logic               eng_done_i,
    input  logic [ICV_W-1:0]   eng_icv_i,
    output logic               busy_o,
    output logic               op_done_o,
    output logic [NUM_ERR-1:0] err_flags_o,
    output logic               irq_o
);

    mode_t              mode_q;
    logic [KEY_W-1:0]   key_bytes_q;
    logic [ICV_W-1:0]   ref_icv_q;
    logic [NUM_ERR-1:0] mask_q, clr_vec, set_vec;
    logic               mode_bad, key_bad;

    icc_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ICV_W  (ICV_W),
        .KEY_W  (KEY_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (reg_we_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .mode_o      (mode_q),
        .key_bytes_o (key_bytes_q),
        .ref_icv_o   (ref_icv_q),
        .mask_o      (mask_q),
        .clr_o       (clr_vec)
    );

    icc_validate #(
        .KEY_W   (KEY_W),
        .REQ_KEY (REQ_KEY)
    ) val_i (
        .mode_i      (mode_q),
        .key_bytes_i (key_bytes_q),
        .mode_bad_o  (mode_bad),
        .key_bad_o   (key_bad)
    );

    icc_seq #(
        .ICV_W (ICV_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_q),
        .mode_bad_i  (mode_bad),
        .key_bad_i   (key_bad),
        .eng_done_i  (eng_done_i),
        .eng_icv_i   (eng_icv_i),
        .ref_icv_i   (ref_icv_q),
        .busy_o      (busy_o),
        .eng_go_o    (eng_go_o),
        .eng_f9_o    (eng_f9_o),
        .eng_init_o  (eng_init_o),
        .eng_final_o (eng_final_o),
        .op_done_o   (op_done_o),
        .set_o       (set_vec)
    );

    icc_errs #(
        .N (NUM_ERR)
    ) errs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .mask_i  (mask_q),
        .flags_o (err_flags_o),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/icc_checker.sv
// Module: protocol and flag checker for icv_check_ctrl, attached by bind.
// Assumes: address 4 is the flag clear address and mode bit 0 marks reserved codes.
module icc_checker #(
    parameter int ADDR_W  = 3,
    parameter int NUM_ERR = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic               start_i,
    input logic               eng_go_o,
    input logic               busy_o,
    input logic               op_done_o,
    input logic [NUM_ERR-1:0] err_flags_o,
    input logic               irq_o,
    input logic [1:0]         fn_i
);

    // R2: a launch is always accompanied by busy.
    p_go_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go_o |-> busy_o);

    // R2: the launch strobe lasts one cycle.
    p_go_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go_o |=> !eng_go_o);

    // R2: the end pulse comes with busy already low.
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_o |-> !busy_o);

    // R3: a reserved code refuses the start and flags illegal mode.
    p_reserved_nogo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && fn_i[0]) |=> (!eng_go_o && err_flags_o[1]));

    // R9: without a clear write, no flag ever falls.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we_i && (reg_addr_i == ADDR_W'(4)))
            |-> ((err_flags_o & $past(err_flags_o)) == $past(err_flags_o)));

    // R10: no flag, no interrupt.
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags_o == '0) |-> !irq_o);

    // R11: a start while busy never launches.
    p_busy_nostart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> !eng_go_o);

endmodule

bind icv_check_ctrl icc_checker #(
    .ADDR_W  (ADDR_W),
    .NUM_ERR (icc_pkg::NUM_ERR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .start_i     (start_i),
    .eng_go_o    (eng_go_o),
    .busy_o      (busy_o),
    .op_done_o   (op_done_o),
    .err_flags_o (err_flags_o),
    .irq_o       (irq_o),
    .fn_i        (mode_q.fn)
);

// File: tb/icv_check_ctrl_tb_top.sv
// Bench: scoreboard of expected launches plus direct flag and strobe checks.
module icv_check_ctrl_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic        start_i = 1'b0;
    logic        eng_done_i = 1'b0;
    logic [31:0] eng_icv_i = '0;
    logic        eng_go_o, eng_f9_o, eng_init_o, eng_final_o;
    logic        busy_o, op_done_o, irq_o;
    logic [2:0]  err_flags_o;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic f9;
        logic init;
        logic fin;
    } go_t;
    go_t exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    icv_check_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .start_i     (start_i),
        .eng_go_o    (eng_go_o),
        .eng_f9_o    (eng_f9_o),
        .eng_init_o  (eng_init_o),
        .eng_final_o (eng_final_o),
        .eng_done_i  (eng_done_i),
        .eng_icv_i   (eng_icv_i),
        .busy_o      (busy_o),
        .op_done_o   (op_done_o),
        .err_flags_o (err_flags_o),
        .irq_o       (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: every launch must match the head of the expected queue (R2, R6).
    always @(negedge clk) begin
        if (rst_n && eng_go_o) begin
            if (exp_q.size() == 0) begin
                check("R2/R11 unexpected go", 1, 0);
            end else begin
                go_t e;
                e = exp_q.pop_front();
                check("R2 go function", {31'b0, eng_f9_o}, {31'b0, e.f9});
                check("R6 go init", {31'b0, eng_init_o}, {31'b0, e.init});
                check("R6 go final", {31'b0, eng_final_o}, {31'b0, e.fin});
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    function automatic logic [31:0] mw(input logic [1:0] fn, input logic cmp,
                                       input logic pe, input logic init);
        return {27'b0, init, pe, cmp, fn};
    endfunction

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    // Driver: one legal operation, expected launch pushed to the scoreboard.
    task automatic run_op(input logic [1:0] fn, input logic cmp, input logic pe,
                          input logic init, input logic [31:0] calc,
                          input logic [31:0] refv);
        go_t e;
        wr(3'd2, refv);
        wr(3'd0, mw(fn, cmp, pe, init));
        e.f9 = (fn == 2'b10); e.init = init; e.fin = pe && (fn == 2'b10);
        exp_q.push_back(e);
        pulse_start();
        check("R2 busy after go", {31'b0, busy_o}, 1);
        @(negedge clk); @(negedge clk);
        eng_done_i = 1'b1; eng_icv_i = calc;
        @(negedge clk);
        eng_done_i = 1'b0;
        check("R2 op_done pulse", {31'b0, op_done_o}, 1);
        check("R2 busy low after done", {31'b0, busy_o}, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 flags", {29'b0, err_flags_o}, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
        check("R1 busy", {31'b0, busy_o}, 0);
        check("R1 go", {31'b0, eng_go_o}, 0);
        check("R1 done", {31'b0, op_done_o}, 0);
        rst_n = 1'b1;

        // R1, R4: key length is 0 after reset, so a start is refused.
        wr(3'd0, mw(2'b00, 0, 0, 1));
        pulse_start();
        check("R1 key zero after reset -> key flag", {29'b0, err_flags_o}, 3'b100);
        check("R10 irq on key flag", {31'b0, irq_o}, 1);
        wr(3'd4, 32'h4);
        check("R9 clear key flag", {29'b0, err_flags_o}, 0);

        // R2, R8: confidentiality function, compare requested but not applied.
        wr(3'd1, 32'd16);
        run_op(2'b00, 1, 1, 1, 32'hDEAD0001, 32'h12345678);
        check("R8 no compare for conf function", {29'b0, err_flags_o}, 0);

        // R7: integrity compare, equal values.
        run_op(2'b10, 1, 1, 1, 32'hCAFEF00D, 32'hCAFEF00D);
        check("R7 match sets nothing", {29'b0, err_flags_o}, 0);

        // R7: integrity compare, unequal values.
        run_op(2'b10, 1, 1, 0, 32'hCAFEF00E, 32'hCAFEF00D);
        check("R7 mismatch flag", {29'b0, err_flags_o}, 3'b001);
        check("R10 irq on mismatch", {31'b0, irq_o}, 1);

        // R10: masking hides the interrupt but keeps the flag.
        wr(3'd3, 32'h1);
        check("R10 masked irq", {31'b0, irq_o}, 0);
        check("R10 flag kept under mask", {29'b0, err_flags_o}, 3'b001);
        wr(3'd3, 32'h0);
        check("R10 unmasked irq", {31'b0, irq_o}, 1);

        // R9: same-cycle set and clear of bit 0: set wins.
        wr(3'd2, 32'h0000_0001);
        wr(3'd0, mw(2'b10, 1, 1, 1));
        begin
            go_t e;
            e.f9 = 1; e.init = 1; e.fin = 1;
            exp_q.push_back(e);
        end
        pulse_start();
        @(negedge clk);
        eng_done_i = 1'b1; eng_icv_i = 32'h0000_0002;
        reg_we_i = 1'b1; reg_addr_i = 3'd4; reg_wdata_i = 32'h1;
        @(negedge clk);
        eng_done_i = 1'b0; reg_we_i = 1'b0;
        check("R9 set wins over clear", {29'b0, err_flags_o}, 3'b001);
        wr(3'd4, 32'h1);
        check("R9 clear alone", {29'b0, err_flags_o}, 0);

        // R8: compare bit clear, and process-end clear.
        run_op(2'b10, 0, 1, 1, 32'h1, 32'h2);
        check("R8 compare off", {29'b0, err_flags_o}, 0);
        run_op(2'b10, 1, 0, 0, 32'h1, 32'h2);
        check("R8 message incomplete", {29'b0, err_flags_o}, 0);

        // R3: reserved codes 01 and 11.
        wr(3'd0, mw(2'b01, 1, 1, 1));
        pulse_start();
        check("R3 code 01 flag", {29'b0, err_flags_o}, 3'b010);
        check("R3 code 01 not busy", {31'b0, busy_o}, 0);
        wr(3'd4, 32'h7);
        wr(3'd0, mw(2'b11, 0, 0, 0));
        pulse_start();
        check("R3 code 11 flag", {29'b0, err_flags_o}, 3'b010);
        wr(3'd4, 32'h7);

        // R4: wrong key lengths.
        wr(3'd1, 32'd15);
        wr(3'd0, mw(2'b10, 1, 1, 1));
        pulse_start();
        check("R4 key 15", {29'b0, err_flags_o}, 3'b100);
        wr(3'd4, 32'h7);
        wr(3'd1, 32'd17);
        pulse_start();
        check("R4 key 17", {29'b0, err_flags_o}, 3'b100);
        wr(3'd4, 32'h7);

        // R5: re-initialize clears the key length.
        wr(3'd1, 32'd16);
        wr(3'd5, 32'h0);
        pulse_start();
        check("R5 reinit clears key", {29'b0, err_flags_o}, 3'b100);
        wr(3'd4, 32'h7);
        wr(3'd1, 32'd16);

        // R11: start while busy is ignored.
        wr(3'd0, mw(2'b00, 0, 0, 1));
        begin
            go_t e;
            e.f9 = 0; e.init = 1; e.fin = 0;
            exp_q.push_back(e);
        end
        pulse_start();
        pulse_start();
        check("R11 still busy", {31'b0, busy_o}, 1);
        @(negedge clk);
        eng_done_i = 1'b1; eng_icv_i = 32'h0;
        @(negedge clk);
        eng_done_i = 1'b0;
        check("R11 busy low after done", {31'b0, busy_o}, 0);
        check("R11 no flag", {29'b0, err_flags_o}, 0);

        repeat (3) @(negedge clk);
        check("R2 all expected launches seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule